// File: doc/BRIEF.md
# Byte-Bus Loader for a 12-bit DAC Code Register

This block sits between an 8-bit processor bus and a 12-bit parallel DAC. It decodes synchronous bus writes and keeps a 4-bit holding register for the upper part of the code. It presents a 12-bit code word to the converter that changes only when a complete word is committed, so the converter never sees a partly updated value.

Two loading schemes are provided, chosen by a mode input. In byte mode the processor first writes the high nibble to one decoded address. A later write of the low byte to a second address commits all twelve bits at once. In address-carried mode a single write is enough. The top address bits select a 4096-location window that belongs to this converter, and the low twelve address bits are the code. The data byte is not used in this mode.

An optional conversion lets software supply signed two's complement codes. When it is enabled, bit 11 of the committed word is inverted, which gives the offset-binary code the converter expects. A one-cycle pulse marks every commit.

Top module: `bytebus_dac_if`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the DAC code, the held nibble and `load_pulse` are cleared to zero, even if a write strobe is active.
- R2: A write happens only at a rising edge where both `bus_cs_n` and `bus_wr_n` are low. At any other edge, `dac_code` and the held nibble keep their values and no pulse is produced.
- R3: When `mode_sel`=0 (byte mode), a write to address `HI_ADDR` stores `bus_wdata[3:0]` as the held nibble and leaves `dac_code` unchanged. If several such writes occur, only the latest nibble is kept.
- R4: When `mode_sel`=0, a write to address `LO_ADDR` loads `dac_code` with {held nibble, `bus_wdata[7:0]`}, with the nibble in bits 11:8. All 12 bits change at that single edge.
- R5: When `mode_sel`=0, writes to any address other than `HI_ADDR` and `LO_ADDR` have no effect.
- R6: When `mode_sel`=1 (address-carried mode), a write with `bus_addr[15:12]` equal to `BLK_ID` loads `dac_code` with `bus_addr[11:0]`. `bus_wdata` is not used, and writes to other windows have no effect.
- R7: When `mode_sel`=1, a write to `HI_ADDR` does not change the held nibble. (With the default parameters, `HI_ADDR` lies outside the `BLK_ID` window.)
- R8: When `signed_en`=1 at the commit edge, bit 11 of the committed word is inverted. For example, 0x7FF loads as 0xFFF, 0x000 as 0x800, and 0x800 as 0x000. The held nibble is always stored without this change.
- R9: `load_pulse` is high for exactly the one cycle that follows each commit edge, alongside the new code. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data byte |
| bus_cs_n | input | 1 | Chip enable, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| mode_sel | input | 1 | 0 = byte mode, 1 = address-carried mode |
| signed_en | input | 1 | 1 = invert bit 11 at commit (two's complement input) |
| dac_code | output | 12 | Code word presented to the converter |
| load_pulse | output | 1 | One-cycle marker of a commit |

## Verification
A stale or corrupted held nibble stays hidden until the next low-byte commit. At that point it appears in bits 11:8 of `dac_code`, one cycle after the write edge. Interleaving nibble writes, address-mode writes and unqualified strobes before each commit exposes such faults. A faulty decode or strobe qualification shows up in the very next cycle, as an unexpected change of `dac_code` or a missing or extra `load_pulse`. A wrong sign conversion shows only in bit 11, so the corner codes 0x7FF, 0x000 and 0x800 are driven explicitly.

// File: rtl/bbdac_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the byte-bus DAC loader.
// Assumes: mode input is a single bit encoded as below.
package bbdac_pkg;
    typedef enum logic {
        MODE_BYTE = 1'b0,   // two writes: high nibble, then low byte
        MODE_ADDR = 1'b1    // one write: code carried in address bits
    } bus_mode_e;
endpackage

// File: rtl/bbdac_decode.sv
`timescale 1ns/1ps
// Address and strobe decode.
// Turns one bus cycle into at most one write enable.
// Assumes: strobes are already synchronous to clk; only one enable can be high.
module bbdac_decode #(
    parameter int                ADDR_W  = 16,
    parameter int                CODE_W  = 12,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0401,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0400,
    parameter logic [ADDR_W-CODE_W-1:0] BLK_ID = 4'hA
) (
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              mode_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              hi_we,
    output logic              lo_we,
    output logic              blk_we
);
    import bbdac_pkg::*;
    localparam int BLK_W = ADDR_W - CODE_W;

    logic strobe;
    logic byte_mode;

    // Qualify the bus cycle and split it by mode and address.
    always_comb begin
        strobe    = !cs_n && !wr_n;
        byte_mode = (bus_mode_e'(mode_sel) == MODE_BYTE);
        hi_we     = strobe &&  byte_mode && (addr == HI_ADDR);
        lo_we     = strobe &&  byte_mode && (addr == LO_ADDR);
        blk_we    = strobe && !byte_mode && (addr[ADDR_W-1 -: BLK_W] == BLK_ID);
    end
endmodule

// File: rtl/bbdac_nibble.sv
`timescale 1ns/1ps
// Holding register for the upper part of the code in byte mode.
// Assumes: we is a single-cycle qualified write enable.
module bbdac_nibble #(
    parameter int HI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [HI_W-1:0] din,
    output logic [HI_W-1:0] nib
);
    // Keep the most recently written nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)  nib <= '0;
        else if (we) nib <= din;
    end
endmodule

// File: rtl/bbdac_codereg.sv
`timescale 1ns/1ps
// Output code register with optional sign conversion and commit marker.
// Assumes: load is high for exactly the cycles that commit a full word.
module bbdac_codereg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              signed_en,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] code,
    output logic              pulse
);
    logic [CODE_W-1:0] conv_code;

    // Flip the top bit to turn a two's complement code into offset binary.
    always_comb conv_code = raw_code ^ {signed_en, {(CODE_W-1){1'b0}}};

    // Commit all bits together and flag the commit for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= load;
            if (load) code <= conv_code;
        end
    end
endmodule

// File: rtl/bytebus_dac_if.sv
`timescale 1ns/1ps
// Byte-bus loader for a 12-bit DAC code register (top level).
// Byte mode: a high-nibble write followed by a low-byte commit.
// Address mode: the low address bits carry the full code.
// Assumes: bus signals are synchronous to clk; reset is synchronous, active low.
module bytebus_dac_if #(
    parameter int                ADDR_W  = 16,
    parameter int                CODE_W  = 12,
    parameter int                BYTE_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0401,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0400,
    parameter logic [ADDR_W-CODE_W-1:0] BLK_ID = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              mode_sel,
    input  logic              signed_en,
    output logic [CODE_W-1:0] dac_code,
    output logic              load_pulse
);
    localparam int HI_W = CODE_W - BYTE_W;

    logic              hi_we, lo_we, blk_we;
    logic [HI_W-1:0]   nib;
    logic [CODE_W-1:0] raw_code;
    logic              load;

    bbdac_decode #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR), .BLK_ID(BLK_ID)
    ) u_decode (
        .cs_n(bus_cs_n), .wr_n(bus_wr_n), .mode_sel(mode_sel),
        .addr(bus_addr), .hi_we(hi_we), .lo_we(lo_we), .blk_we(blk_we)
    );

    bbdac_nibble #(.HI_W(HI_W)) u_nibble (
        .clk(clk), .rst_n(rst_n), .we(hi_we),
        .din(bus_wdata[HI_W-1:0]), .nib(nib)
    );

    // Pick the word source: address bits or held nibble plus data byte.
    always_comb begin
        load     = lo_we || blk_we;
        raw_code = blk_we ? bus_addr[CODE_W-1:0] : {nib, bus_wdata};
    end

    bbdac_codereg #(.CODE_W(CODE_W)) u_codereg (
        .clk(clk), .rst_n(rst_n), .load(load), .signed_en(signed_en),
        .raw_code(raw_code), .code(dac_code), .pulse(load_pulse)
    );
endmodule

// File: rtl/bbdac_checker.sv
`timescale 1ns/1ps
// Port-level property checker for bytebus_dac_if, attached by bind.
module bbdac_checker #(
    parameter int                ADDR_W  = 16,
    parameter int                CODE_W  = 12,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0401,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0400,
    parameter logic [ADDR_W-CODE_W-1:0] BLK_ID = 4'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_wr_n,
    input logic              mode_sel,
    input logic              signed_en,
    input logic [CODE_W-1:0] dac_code,
    input logic              load_pulse
);
    localparam int BLK_W = ADDR_W - CODE_W;

    logic wr_ok, hi_fire, blk_fire, lo_fire;
    always_comb begin
        wr_ok    = !bus_cs_n && !bus_wr_n;
        hi_fire  = wr_ok && !mode_sel && (bus_addr == HI_ADDR);
        lo_fire  = wr_ok && !mode_sel && (bus_addr == LO_ADDR);
        blk_fire = wr_ok &&  mode_sel && (bus_addr[ADDR_W-1 -: BLK_W] == BLK_ID);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_code == '0) && !load_pulse); // R1
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(dac_code) && !load_pulse); // R2
    AST_HI_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        hi_fire |=> $stable(dac_code) && !load_pulse); // R3
    AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        blk_fire |=> dac_code == ($past(bus_addr[CODE_W-1:0]) ^ {$past(signed_en), {(CODE_W-1){1'b0}}})); // R6
    AST_PULSE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_fire || blk_fire) |=> load_pulse); // R9
    AST_PULSE_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && load_pulse |-> $past(lo_fire || blk_fire)); // R9
    AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (dac_code != $past(dac_code)) |-> load_pulse); // R4
endmodule

bind bytebus_dac_if bbdac_checker #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W),
    .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR), .BLK_ID(BLK_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .mode_sel(mode_sel), .signed_en(signed_en),
    .dac_code(dac_code), .load_pulse(load_pulse)
);

// File: tb/bytebus_dac_if_test.sv
`timescale 1ns/1ps
module bytebus_dac_if_test;
    localparam logic [15:0] HI_A = 16'h0401;
    localparam logic [15:0] LO_A = 16'h0400;
    localparam logic [3:0]  BLK  = 4'hA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_cs_n = 1'b1, bus_wr_n = 1'b1;
    logic        mode_sel = 1'b0, signed_en = 1'b0;
    logic [11:0] dac_code;
    logic        load_pulse;

    int n_checks = 0;
    int n_errs   = 0;
    logic [11:0] m_code = '0;
    logic [3:0]  m_nib  = '0;
    logic        m_pulse = 1'b0;

    always #2 clk = ~clk;

    bytebus_dac_if #(.HI_ADDR(HI_A), .LO_ADDR(LO_A), .BLK_ID(BLK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .mode_sel(mode_sel),
        .signed_en(signed_en), .dac_code(dac_code), .load_pulse(load_pulse)
    );

    task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of the requirements: returns the tag the cycle exercises.
    function automatic string model(input logic [15:0] a, input logic [7:0] d,
                                    input logic cs, input logic wr,
                                    input logic m, input logic s);
        logic        ok = !cs && !wr;
        logic [11:0] flip = {s, 11'b0};
        m_pulse = 1'b0;
        if (!ok) return "R2";
        if (!m) begin
            if (a == HI_A) begin m_nib = d[3:0]; return "R3"; end
            if (a == LO_A) begin
                m_code = {m_nib, d} ^ flip; m_pulse = 1'b1;
                return s ? "R8" : "R4";
            end
            return "R5";
        end
        if (a[15:12] == BLK) begin
            m_code = a[11:0] ^ flip; m_pulse = 1'b1;
            return s ? "R8" : "R6";
        end
        return (a == HI_A) ? "R7" : "R6";
    endfunction

    // One bus cycle: drive after a falling edge, check at the next falling edge.
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic cs,
                        input logic wr, input logic m, input logic s);
        string tag;
        bus_addr = a; bus_wdata = d; bus_cs_n = cs; bus_wr_n = wr;
        mode_sel = m; signed_en = s;
        tag = model(a, d, cs, wr, m, s);
        @(posedge clk); @(negedge clk);
        check(dac_code, m_code, tag);
        check({11'b0, load_pulse}, {11'b0, m_pulse}, "R9");
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d, input logic s);
        step(a, d, 1'b0, 1'b0, 1'b0, s);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset with an active commit strobe keeps everything cleared.
        bus_addr = LO_A; bus_wdata = 8'h5A; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dac_code, 12'h000, "R1");
        check({11'b0, load_pulse}, 12'h000, "R1");
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code, 12'h000, "R1");

        // R3/R4: nibble then low byte; repeated nibble keeps the last one.
        wr_byte(HI_A, 8'hF1, 1'b0);
        wr_byte(HI_A, 8'h07, 1'b0);
        wr_byte(LO_A, 8'hC3, 1'b0);
        check(dac_code, 12'h7C3, "R4");
        // R2: only one strobe low, then both high.
        step(LO_A, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0);
        step(LO_A, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
        step(LO_A, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0);
        // R5: other address in byte mode.
        wr_byte(16'h0402, 8'h44, 1'b0);
        // R6: address-carried load, other window ignored.
        step({BLK, 12'h9AB}, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        check(dac_code, 12'h9AB, "R6");
        step({4'h3, 12'h123}, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
        // R7: nibble write in address mode is ignored.
        wr_byte(HI_A, 8'h03, 1'b0);
        step(HI_A, 8'h09, 1'b0, 1'b0, 1'b1, 1'b0);
        wr_byte(LO_A, 8'h55, 1'b0);
        check(dac_code, 12'h355, "R7");
        // R8: sign conversion corners in both modes.
        wr_byte(HI_A, 8'h07, 1'b1);
        wr_byte(LO_A, 8'hFF, 1'b1);
        check(dac_code, 12'hFFF, "R8");
        wr_byte(HI_A, 8'h00, 1'b1);
        wr_byte(LO_A, 8'h00, 1'b1);
        check(dac_code, 12'h800, "R8");
        step({BLK, 12'h800}, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        check(dac_code, 12'h000, "R8");

        // Constrained random mix.
        for (int i = 0; i < 600; i++) begin
            int unsigned k = $urandom % 6;
            logic [15:0] a;
            logic cs = 1'b0, wr = 1'b0;
            case (k)
                0: a = HI_A;
                1: a = LO_A;
                2: a = {BLK, 12'($urandom)};
                3: a = 16'($urandom);
                4: begin a = LO_A; cs = 1'b1; wr = 1'($urandom); end
                default: begin a = {BLK, 12'($urandom)}; wr = 1'b1; end
            endcase
            step(a, 8'($urandom), cs, wr, 1'($urandom % 3 == 0), 1'($urandom));
        end

        // R1: reset mid-run clears a non-zero code.
        step(LO_A, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dac_code, 12'h000, "R1");
        rst_n = 1'b1;
        m_code = '0; m_nib = '0;
        wr_byte(LO_A, 8'h12, 1'b0);
        check(dac_code, 12'h012, "R1");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule